// File: doc/BRIEF.md
# Device Control Register Block

This block is a small byte-wide register file inside a memory device. It is reached through an 8-bit register address that a serial command interface has already decoded. The framing of that interface is not part of this block. Three registers are mapped:

- a configuration register, which selects the device interface width and gates the serial-load write path;
- a power register, which reports the current power state and takes a request to leave powerdown;
- a serial-load data register, whose every write hands one byte to a downstream accumulator.

The power state is also driven by a separate powerdown command strobe. A successful exit request produces a one-cycle exit pulse.

Reads are combinational from the register state. Writes take effect on the next rising clock edge. The asynchronous active-low reset input is passed through a synchronizer, so reset asserts at once and is released on a clock edge.

Top module: `devctl_regs`

## Requirements
- R1: After reset, a read of address 0x02 returns 0x04, a read of 0x03 returns 0x00 and a read of 0x04 returns 0x00. The width output is 3'b100, the serial-load enable is 0 and the power state is 2'b00 (powerdown).
- R2: A write to 0x02 whose bits [2:0] hold a legal width code (3'b010 x4, 3'b011 x8, 3'b100 x16) sets the width output to that code. Reads of 0x02 return {4'b0000, enable bit, width code}.
- R3: A write to 0x02 with a reserved width code (000, 001, 101, 110, 111) leaves the width unchanged. Bit 3 of that same write is still stored.
- R4: Bits [7:4] of address 0x02 read as 0 whatever value was written to them.
- R5: Bit 3 of address 0x02 drives the serial-load enable output: 1 enables the path, 0 disables it.
- R6: A powerdown command strobe sets the power state to 2'b00 on the next edge. Reads of 0x03 return the state in bits [5:4] and 0 in every other bit, including bit 0.
- R7: A write to 0x03 with bit 0 = 1 while in powerdown sets the state to 2'b01 (active). It also raises the exit pulse for exactly one cycle. The same write while already active changes nothing and gives no pulse.
- R8: A write to 0x03 with bit 0 = 0 has no effect. Writes to bits [7:1] of 0x03 never change the state.
- R9: A write to 0x04 stores the byte, which reads back from 0x04. On the next edge the byte appears on the serial-load byte output with a one-cycle push strobe, once per write, including back-to-back writes.
- R10: Reads of any address other than 0x02, 0x03 and 0x04 return 0x00. Writes to them change no register and give no push.
- R11: When a powerdown command and an exit write arrive in the same cycle, the command wins: the state becomes 2'b00 and no exit pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for reg_addr (combinational) |
| pdn_cmd | input | 1 | Powerdown command strobe |
| width_code | output | 3 | Current interface width code |
| serload_en | output | 1 | Serial-load path enable |
| pwr_state | output | 2 | Power state (00 powerdown, 01 active) |
| exit_pulse | output | 1 | One-cycle pulse on leaving powerdown |
| sl_byte | output | 8 | Last byte written to the serial-load register |
| sl_push | output | 1 | One-cycle strobe marking a new sl_byte |

## Verification
The assertions assume that wr_en, reg_addr, wr_data and pdn_cmd are stable around each rising edge and carry no unknown values once reset is released. They also assume pdn_cmd is a strobe, sampled as a command on every cycle it is high. The bench drives all inputs on falling edges and returns wr_en and pdn_cmd to 0 after each operation. The only case with several inputs active at once is the deliberate collision of a powerdown command with an exit write. Outputs are sampled at the falling edge that follows the capturing edge, so each check lands in the first cycle the result can appear.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  localparam int DATA_W = 8;

  // Interface width encodings (legal subset of a 3-bit field)
  localparam logic [2:0] WID_X4  = 3'b010;
  localparam logic [2:0] WID_X8  = 3'b011;
  localparam logic [2:0] WID_X16 = 3'b100;

  // Power states; 2'b10 and 2'b11 are never produced
  localparam logic [1:0] PS_PDN = 2'b00;
  localparam logic [1:0] PS_ACT = 2'b01;

  typedef struct packed {
    logic cfg;
    logic pm;
    logic sl;
  } regsel_t;

  function automatic logic width_legal(input logic [2:0] code);
    return (code == WID_X4) || (code == WID_X8) || (code == WID_X16);
  endfunction

endpackage

// File: rtl/devctl_rst_sync.sv
module devctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/devctl_decode.sv
module devctl_decode
  import devctl_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] PM_ADDR  = 8'h03,
  parameter logic [ADDR_W-1:0] SL_ADDR  = 8'h04
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] cfg_rd,
  input  logic [DATA_W-1:0] pm_rd,
  input  logic [DATA_W-1:0] sl_rd,
  output regsel_t           wsel,
  output logic [DATA_W-1:0] rd_data
);

  regsel_t hit;

  always_comb begin
    hit.cfg = (addr == CFG_ADDR);
    hit.pm  = (addr == PM_ADDR);
    hit.sl  = (addr == SL_ADDR);
  end

  assign wsel = wr_en ? hit : '0;

  always_comb begin
    rd_data = '0;
    if (hit.cfg) rd_data = cfg_rd;
    if (hit.pm)  rd_data = pm_rd;
    if (hit.sl)  rd_data = sl_rd;
  end

endmodule

// File: rtl/devctl_cfg_reg.sv
module devctl_cfg_reg
  import devctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        wdata,
  output logic [2:0]        width_code,
  output logic              serload_en,
  output logic [DATA_W-1:0] rd_val
);

  logic [2:0] width_q, width_d;
  logic       sle_q, sle_d;
  logic       width_ce;

  assign width_ce = wr && width_legal(wdata[2:0]);

  always_comb begin
    width_d = width_q;
    sle_d   = sle_q;
    if (width_ce) width_d = wdata[2:0];
    if (wr)       sle_d   = wdata[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= WID_X16;
      sle_q   <= 1'b0;
    end else begin
      width_q <= width_d;
      sle_q   <= sle_d;
    end
  end

  assign width_code = width_q;
  assign serload_en = sle_q;
  assign rd_val     = {4'b0000, sle_q, width_q};

endmodule

// File: rtl/devctl_pm_ctrl.sv
module devctl_pm_ctrl
  import devctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              exit_bit,
  input  logic              pdn_cmd,
  output logic [1:0]        pwr_state,
  output logic              exit_pulse,
  output logic [DATA_W-1:0] rd_val
);

  logic [1:0] state_q, state_d;
  logic       pulse_q, pulse_d;
  logic       exit_req;

  assign exit_req = wr && exit_bit && (state_q == PS_PDN) && !pdn_cmd;

  always_comb begin
    state_d = state_q;
    if (pdn_cmd)       state_d = PS_PDN;
    else if (exit_req) state_d = PS_ACT;
    pulse_d = exit_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_PDN;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign pwr_state  = state_q;
  assign exit_pulse = pulse_q;
  assign rd_val     = {2'b00, state_q, 4'b0000};

endmodule

// File: rtl/devctl_sl_reg.sv
module devctl_sl_reg
  import devctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sl_byte,
  output logic              sl_push,
  output logic [DATA_W-1:0] rd_val
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              push_q, push_d;

  always_comb begin
    data_d = data_q;
    if (wr) data_d = wdata;
    push_d = wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      push_q <= 1'b0;
    end else begin
      data_q <= data_d;
      push_q <= push_d;
    end
  end

  assign sl_byte = data_q;
  assign sl_push = push_q;
  assign rd_val  = data_q;

endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
  import devctl_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] CFG_ADDR    = 8'h02,
  parameter logic [7:0] PM_ADDR     = 8'h03,
  parameter logic [7:0] SL_ADDR     = 8'h04,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pdn_cmd,
  output logic [2:0]        width_code,
  output logic              serload_en,
  output logic [1:0]        pwr_state,
  output logic              exit_pulse,
  output logic [DATA_W-1:0] sl_byte,
  output logic              sl_push
);

  logic              rst_n_int;
  regsel_t           wsel;
  logic [DATA_W-1:0] cfg_rd, pm_rd, sl_rd;

  devctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_int)
  );

  devctl_decode #(
    .ADDR_W  (ADDR_W),
    .CFG_ADDR(CFG_ADDR[ADDR_W-1:0]),
    .PM_ADDR (PM_ADDR[ADDR_W-1:0]),
    .SL_ADDR (SL_ADDR[ADDR_W-1:0])
  ) u_dec (
    .addr   (reg_addr),
    .wr_en  (wr_en),
    .cfg_rd (cfg_rd),
    .pm_rd  (pm_rd),
    .sl_rd  (sl_rd),
    .wsel   (wsel),
    .rd_data(rd_data)
  );

  devctl_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr        (wsel.cfg),
    .wdata     (wr_data[3:0]),
    .width_code(width_code),
    .serload_en(serload_en),
    .rd_val    (cfg_rd)
  );

  devctl_pm_ctrl u_pm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr        (wsel.pm),
    .exit_bit  (wr_data[0]),
    .pdn_cmd   (pdn_cmd),
    .pwr_state (pwr_state),
    .exit_pulse(exit_pulse),
    .rd_val    (pm_rd)
  );

  devctl_sl_reg u_sl (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr     (wsel.sl),
    .wdata  (wr_data),
    .sl_byte(sl_byte),
    .sl_push(sl_push),
    .rd_val (sl_rd)
  );

endmodule

// File: rtl/devctl_regs_chk.sv
module devctl_regs_chk #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] CFG_ADDR = 8'h02,
  parameter logic [7:0] PM_ADDR  = 8'h03,
  parameter logic [7:0] SL_ADDR  = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              pdn_cmd,
  input logic [2:0]        width_code,
  input logic              serload_en,
  input logic [1:0]        pwr_state,
  input logic              exit_pulse,
  input logic [7:0]        sl_byte,
  input logic              sl_push
);

  logic cfg_wr, sl_wr, mapped;
  assign cfg_wr = wr_en && (reg_addr == CFG_ADDR[ADDR_W-1:0]);
  assign sl_wr  = wr_en && (reg_addr == SL_ADDR[ADDR_W-1:0]);
  assign mapped = (reg_addr == CFG_ADDR[ADDR_W-1:0]) ||
                  (reg_addr == PM_ADDR[ADDR_W-1:0])  ||
                  (reg_addr == SL_ADDR[ADDR_W-1:0]);

  a_r2_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (width_code == 3'b010) || (width_code == 3'b011) || (width_code == 3'b100));

  a_r3_reserved_width_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !((wr_data[2:0] == 3'b010) || (wr_data[2:0] == 3'b011) ||
                 (wr_data[2:0] == 3'b100))) |=> $stable(width_code));

  a_r5_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (serload_en == $past(wr_data[3])));

  a_r6_pdn_enters: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_cmd |=> (pwr_state == 2'b00));

  a_r6_state_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state[1] == 1'b0);

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |=> !exit_pulse);

  a_r7_pulse_transition: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> (pwr_state == 2'b01) && ($past(pwr_state) == 2'b00));

  a_r9_push_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    sl_push |-> $past(sl_wr) && (sl_byte == $past(wr_data)));

  a_r9_write_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    sl_wr |=> sl_push);

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rd_data == 8'h00));

endmodule

bind devctl_regs devctl_regs_chk #(
  .ADDR_W  (ADDR_W),
  .CFG_ADDR(CFG_ADDR),
  .PM_ADDR (PM_ADDR),
  .SL_ADDR (SL_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .pdn_cmd   (pdn_cmd),
  .width_code(width_code),
  .serload_en(serload_en),
  .pwr_state (pwr_state),
  .exit_pulse(exit_pulse),
  .sl_byte   (sl_byte),
  .sl_push   (sl_push)
);

// File: tb/devctl_regs_test.sv
module devctl_regs_test;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       pdn_cmd;
  logic [2:0] width_code;
  logic       serload_en;
  logic [1:0] pwr_state;
  logic       exit_pulse;
  logic [7:0] sl_byte;
  logic       sl_push;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  devctl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pdn_cmd(pdn_cmd),
    .width_code(width_code), .serload_en(serload_en), .pwr_state(pwr_state),
    .exit_pulse(exit_pulse), .sl_byte(sl_byte), .sl_push(sl_push)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic pdn();
    @(negedge clk);
    pdn_cmd = 1'b1;
    @(negedge clk);
    pdn_cmd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h02, v); check("R1 cfg", v, 8'h04);
    rd(8'h03, v); check("R1 pm", v, 8'h00);
    rd(8'h04, v); check("R1 sl", v, 8'h00);
    check("R1 width", {5'd0, width_code}, 8'h04);
    check("R1 enable", {7'd0, serload_en}, 8'h00);
    check("R1 state", {6'd0, pwr_state}, 8'h00);
  endtask

  task automatic t_cfg_width();
    logic [7:0] v;
    wr(8'h02, 8'h02); rd(8'h02, v); check("R2 x4", v, 8'h02);
    check("R2 width port", {5'd0, width_code}, 8'h02);
    wr(8'h02, 8'h0B); rd(8'h02, v); check("R2 x8 R5 enable", v, 8'h0B);
    check("R5 enable on", {7'd0, serload_en}, 8'h01);
    wr(8'h02, 8'h04); rd(8'h02, v); check("R2 x16", v, 8'h04);
    check("R5 enable off", {7'd0, serload_en}, 8'h00);
  endtask

  task automatic t_cfg_reserved();
    logic [7:0] v;
    wr(8'h02, 8'h03);
    wr(8'h02, 8'h0F); rd(8'h02, v); check("R3 code 111 kept, enable set", v, 8'h0B);
    wr(8'h02, 8'h00); rd(8'h02, v); check("R3 code 000", v, 8'h03);
    wr(8'h02, 8'h01); rd(8'h02, v); check("R3 code 001", v, 8'h03);
    wr(8'h02, 8'h05); rd(8'h02, v); check("R3 code 101", v, 8'h03);
    wr(8'h02, 8'h06); rd(8'h02, v); check("R3 code 110", v, 8'h03);
    wr(8'h02, 8'hF2); rd(8'h02, v); check("R4 upper bits read 0", v, 8'h02);
  endtask

  task automatic t_pm_exit();
    logic [7:0] v;
    wr(8'h03, 8'h01);
    check("R7 pulse high", {7'd0, exit_pulse}, 8'h01);
    check("R7 state active", {6'd0, pwr_state}, 8'h01);
    @(negedge clk);
    check("R7 pulse one cycle", {7'd0, exit_pulse}, 8'h00);
    rd(8'h03, v); check("R6 read active", v, 8'h10);
    wr(8'h03, 8'h01);
    check("R7 no pulse when active", {7'd0, exit_pulse}, 8'h00);
    check("R7 stays active", {6'd0, pwr_state}, 8'h01);
    pdn();
    check("R6 pdn enters", {6'd0, pwr_state}, 8'h00);
    rd(8'h03, v); check("R6 read powerdown", v, 8'h00);
  endtask

  task automatic t_pm_ignored();
    logic [7:0] v;
    wr(8'h03, 8'h30); rd(8'h03, v); check("R8 state bits not writable", v, 8'h00);
    wr(8'h03, 8'hFE); rd(8'h03, v); check("R8 exit bit 0 in powerdown", v, 8'h00);
    check("R8 no pulse", {7'd0, exit_pulse}, 8'h00);
    wr(8'h03, 8'h01);
    wr(8'h03, 8'h00); rd(8'h03, v); check("R8 zero write while active", v, 8'h10);
    wr(8'h03, 8'h21); rd(8'h03, v); check("R8 state bits ignored while active", v, 8'h10);
    pdn();
  endtask

  task automatic t_pm_collide();
    logic [7:0] v;
    @(negedge clk);
    reg_addr = 8'h03; wr_data = 8'h01; wr_en = 1'b1; pdn_cmd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pdn_cmd = 1'b0;
    check("R11 no pulse", {7'd0, exit_pulse}, 8'h00);
    rd(8'h03, v); check("R11 stays powerdown", v, 8'h00);
    wr(8'h03, 8'h01);
    @(negedge clk);
    reg_addr = 8'h03; wr_data = 8'h01; wr_en = 1'b1; pdn_cmd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pdn_cmd = 1'b0;
    check("R11 pdn from active wins", {6'd0, pwr_state}, 8'h00);
  endtask

  task automatic t_sl();
    logic [7:0] v;
    wr(8'h04, 8'hA5);
    check("R9 push", {7'd0, sl_push}, 8'h01);
    check("R9 byte", sl_byte, 8'hA5);
    @(negedge clk);
    check("R9 push one cycle", {7'd0, sl_push}, 8'h00);
    rd(8'h04, v); check("R9 readback", v, 8'hA5);
    @(negedge clk);
    reg_addr = 8'h04; wr_data = 8'h3C; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 8'h5A;
    check("R9 b2b first push", {7'd0, sl_push}, 8'h01);
    check("R9 b2b first byte", sl_byte, 8'h3C);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 b2b second push", {7'd0, sl_push}, 8'h01);
    check("R9 b2b second byte", sl_byte, 8'h5A);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(8'h02, 8'h0A);
    wr(8'h05, 8'hFF);
    check("R10 no push", {7'd0, sl_push}, 8'h00);
    rd(8'h05, v); check("R10 read 0x05", v, 8'h00);
    rd(8'h00, v); check("R10 read 0x00", v, 8'h00);
    rd(8'hFF, v); check("R10 read 0xFF", v, 8'h00);
    wr(8'h82, 8'h04); wr(8'h01, 8'h01);
    rd(8'h02, v); check("R10 cfg untouched", v, 8'h0A);
    rd(8'h03, v); check("R10 pm untouched", v, 8'h00);
    rd(8'h04, v); check("R10 sl untouched", v, 8'h5A);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; wr_en = 1'b0; wr_data = '0; pdn_cmd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_width();
    t_cfg_reserved();
    t_pm_exit();
    t_pm_ignored();
    t_pm_collide();
    t_sl();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule